// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block is the host-facing configuration front end of a multi-function peripheral device. The host reaches it through a pair of I/O ports: an index port and a data port at the next address. A strap input picks one of two port locations. Register access is locked until the host writes an unlock key to the index port. While unlocked, an index write selects a configuration register, and data-port reads and writes reach that register. A lock key written to the index port closes access again.

The registers hold the settings for the device's functions:

- two serial-port base addresses and their interrupt selects,
- a parallel-port base address and its mode,
- a pin configuration byte that can turn on a shared interrupt pin,
- a global valid bit,
- a fixed device identifier.

Base addresses are stored in compressed form, as address bits [9:2]. The block widens them back into 10-bit decoded bases. It also drives one enable per function, which the serial, parallel and interrupt logic outside this block use.

The key handler is a two-state machine. `KS_LOCKED` moves to `KS_OPEN` on the transition UNLOCK, which is an index-port write of 0x55. `KS_OPEN` moves back to `KS_LOCKED` on the transition LOCK, which is an index-port write of 0xAA. Every other access leaves the state unchanged.

Top module: `sio_cfg_port`

## Requirements
- R1: With `strap_alt`=0 the index port is at 0x3F0 and the data port at 0x3F1. With `strap_alt`=1 they are at 0x370 and 0x371. Accesses to any other address have no effect, and a read at any other address returns 0xFF.
- R2: In `KS_LOCKED`, an index-port write of 0x55 enters `KS_OPEN`. `cfg_mode` is 1 from the next cycle.
- R3: In `KS_OPEN`, an index-port write of 0xAA returns to `KS_LOCKED` and clears the selected index to 0x00. Any other index-port write in `KS_OPEN` selects that register.
- R4: In `KS_LOCKED`, data-port reads return 0xFF, and data-port writes and index-port writes other than 0x55 change nothing.
- R5: Register 0x0D reads 0x04 at all times. Writes to it are ignored.
- R6: Registers 0x24 and 0x25 store the written byte with bit 0 forced to 0. `ser0_base` and `ser1_base` equal the stored value shifted left by 2, so each base is 8-byte aligned.
- R7: Register 0x23 holds the parallel base, and `par_base` equals its value shifted left by 2. `par_mode` equals bits [1:0] of register 0x04, with the codes 0=SPP, 1=EPP+SPP, 2=ECP, 3=EPP+ECP.
- R8: For register 0x28, bits [7:4] drive `ser0_irq` and bits [3:0] drive `ser1_irq`. The value 0 means no interrupt is assigned.
- R9: Register 0x00 reads back the byte written, and bit 7 of it is the valid bit. `ser0_en`, `ser1_en` and `par_en` are 1 only while the valid bit is 1 and the matching base is nonzero.
- R10: `shint_en` is 1 only while the valid bit and bits 7 and 2 of register 0x03 are all 1.
- R11: Indices with no register read 0x00, and writes to them are ignored.
- R12: Reset enters `KS_LOCKED`, sets the index to 0x00 and clears every register except the device ID.
- R13: The decoded outputs and `cfg_mode` change only in the cycle after a host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_alt | input | 1 | Port location select: 0 gives 0x3F0/0x3F1, 1 gives 0x370/0x371 |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, combinational during `io_rd` |
| cfg_mode | output | 1 | 1 while in `KS_OPEN` |
| ser0_base | output | 10 | Decoded base address of serial port 0 |
| ser1_base | output | 10 | Decoded base address of serial port 1 |
| par_base | output | 10 | Decoded base address of the parallel port |
| ser0_irq | output | 4 | Interrupt select code for serial port 0 |
| ser1_irq | output | 4 | Interrupt select code for serial port 1 |
| par_mode | output | 2 | Parallel port mode code |
| ser0_en | output | 1 | Serial port 0 enable |
| ser1_en | output | 1 | Serial port 1 enable |
| par_en | output | 1 | Parallel port enable |
| shint_en | output | 1 | Shared interrupt pin enable |

## Verification
A key state machine left in the wrong state shows at once. The next data-port read returns 0xFF where a register value is expected, or the reverse, and `cfg_mode` shows the same fault one cycle after the key write. A wrong selected index shows on the first data-port read, as the wrong register's value or as 0x00. A register corrupted by a stray write shows on the decoded outputs in the cycle after that write, or when the register is next read. The bench reads each register back through the data port, samples the decoded outputs once a sequence ends, and repeats key sequences at the other strap location.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    localparam int DW = 8;
    localparam int AW = 16;
    localparam int BW = 10;

    typedef enum logic [0:0] {
        KS_LOCKED = 1'b0,
        KS_OPEN   = 1'b1
    } key_state_t;

    localparam logic [DW-1:0] KEY_UNLOCK = 8'h55;
    localparam logic [DW-1:0] KEY_LOCK   = 8'hAA;
    localparam logic [DW-1:0] DEV_ID_VAL = 8'h04;

    localparam logic [DW-1:0] IX_VALID = 8'h00;
    localparam logic [DW-1:0] IX_PINS  = 8'h03;
    localparam logic [DW-1:0] IX_PMODE = 8'h04;
    localparam logic [DW-1:0] IX_DEVID = 8'h0D;
    localparam logic [DW-1:0] IX_PBASE = 8'h23;
    localparam logic [DW-1:0] IX_S0BAS = 8'h24;
    localparam logic [DW-1:0] IX_S1BAS = 8'h25;
    localparam logic [DW-1:0] IX_IRQS  = 8'h28;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
    import sio_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idx_wr,
    input  logic [DW-1:0] wdata,
    output logic          open,
    output logic [DW-1:0] index
);
    key_state_t state_q, state_d;
    logic [DW-1:0] index_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KS_LOCKED;
            index   <= '0;
        end else begin
            state_q <= state_d;
            index   <= index_d;
        end
    end

    // next state and index select
    always_comb begin
        state_d = state_q;
        index_d = index;
        unique case (state_q)
            KS_LOCKED: begin
                if (idx_wr && wdata == KEY_UNLOCK) state_d = KS_OPEN;   // UNLOCK
            end
            KS_OPEN: begin
                if (idx_wr) begin
                    if (wdata == KEY_LOCK) begin                        // LOCK
                        state_d = KS_LOCKED;
                        index_d = '0;
                    end else begin
                        index_d = wdata;
                    end
                end
            end
            default: state_d = KS_LOCKED;
        endcase
    end

    assign open = (state_q == KS_OPEN);
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] index,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_val,
    output logic [DW-1:0] r_valid,
    output logic [DW-1:0] r_pins,
    output logic [DW-1:0] r_pmode,
    output logic [DW-1:0] r_pbase,
    output logic [DW-1:0] r_s0bas,
    output logic [DW-1:0] r_s1bas,
    output logic [DW-1:0] r_irqs
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_valid <= '0;
            r_pins  <= '0;
            r_pmode <= '0;
            r_pbase <= '0;
            r_s0bas <= '0;
            r_s1bas <= '0;
            r_irqs  <= '0;
        end else if (wr_en) begin
            unique case (index)
                IX_VALID: r_valid <= wdata;
                IX_PINS:  r_pins  <= wdata;
                IX_PMODE: r_pmode <= wdata;
                IX_PBASE: r_pbase <= wdata;
                IX_S0BAS: r_s0bas <= {wdata[DW-1:1], 1'b0};
                IX_S1BAS: r_s1bas <= {wdata[DW-1:1], 1'b0};
                IX_IRQS:  r_irqs  <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (index)
            IX_VALID: rd_val = r_valid;
            IX_PINS:  rd_val = r_pins;
            IX_PMODE: rd_val = r_pmode;
            IX_DEVID: rd_val = DEV_ID_VAL;
            IX_PBASE: rd_val = r_pbase;
            IX_S0BAS: rd_val = r_s0bas;
            IX_S1BAS: rd_val = r_s1bas;
            IX_IRQS:  rd_val = r_irqs;
            default:  rd_val = '0;
        endcase
    end
endmodule

// File: rtl/sio_out_decode.sv
module sio_out_decode
    import sio_cfg_pkg::*;
(
    input  logic [DW-1:0] r_valid,
    input  logic [DW-1:0] r_pins,
    input  logic [DW-1:0] r_pmode,
    input  logic [DW-1:0] r_pbase,
    input  logic [DW-1:0] r_s0bas,
    input  logic [DW-1:0] r_s1bas,
    input  logic [DW-1:0] r_irqs,
    output logic [BW-1:0] ser0_base,
    output logic [BW-1:0] ser1_base,
    output logic [BW-1:0] par_base,
    output logic [3:0]    ser0_irq,
    output logic [3:0]    ser1_irq,
    output logic [1:0]    par_mode,
    output logic          ser0_en,
    output logic          ser1_en,
    output logic          par_en,
    output logic          shint_en
);
    localparam int SH = BW - DW;
    logic valid;

    assign valid     = r_valid[DW-1];
    assign ser0_base = {r_s0bas, {SH{1'b0}}};
    assign ser1_base = {r_s1bas, {SH{1'b0}}};
    assign par_base  = {r_pbase, {SH{1'b0}}};
    assign ser0_irq  = r_irqs[7:4];
    assign ser1_irq  = r_irqs[3:0];
    assign par_mode  = r_pmode[1:0];
    assign ser0_en   = valid && (r_s0bas != '0);
    assign ser1_en   = valid && (r_s1bas != '0);
    assign par_en    = valid && (r_pbase != '0);
    assign shint_en  = valid && r_pins[7] && r_pins[2];
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter logic [AW-1:0] PORT_MAIN = 16'h03F0,
    parameter logic [AW-1:0] PORT_ALT  = 16'h0370
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strap_alt,
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic          io_rd,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    output logic          cfg_mode,
    output logic [BW-1:0] ser0_base,
    output logic [BW-1:0] ser1_base,
    output logic [BW-1:0] par_base,
    output logic [3:0]    ser0_irq,
    output logic [3:0]    ser1_irq,
    output logic [1:0]    par_mode,
    output logic          ser0_en,
    output logic          ser1_en,
    output logic          par_en,
    output logic          shint_en
);
    logic [AW-1:0] idx_port, dat_port;
    logic          hit_idx, hit_dat, open;
    logic [DW-1:0] index, rd_val;
    logic [DW-1:0] r_valid, r_pins, r_pmode, r_pbase, r_s0bas, r_s1bas, r_irqs;

    assign idx_port = strap_alt ? PORT_ALT : PORT_MAIN;
    assign dat_port = idx_port + AW'(1);
    assign hit_idx  = (io_addr == idx_port);
    assign hit_dat  = (io_addr == dat_port);

    sio_key_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .idx_wr(io_wr && hit_idx),
        .wdata(io_wdata), .open(open), .index(index)
    );

    sio_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(io_wr && hit_dat && open),
        .index(index), .wdata(io_wdata), .rd_val(rd_val),
        .r_valid(r_valid), .r_pins(r_pins), .r_pmode(r_pmode),
        .r_pbase(r_pbase), .r_s0bas(r_s0bas), .r_s1bas(r_s1bas), .r_irqs(r_irqs)
    );

    sio_out_decode u_dec (
        .r_valid(r_valid), .r_pins(r_pins), .r_pmode(r_pmode),
        .r_pbase(r_pbase), .r_s0bas(r_s0bas), .r_s1bas(r_s1bas), .r_irqs(r_irqs),
        .ser0_base(ser0_base), .ser1_base(ser1_base), .par_base(par_base),
        .ser0_irq(ser0_irq), .ser1_irq(ser1_irq), .par_mode(par_mode),
        .ser0_en(ser0_en), .ser1_en(ser1_en), .par_en(par_en), .shint_en(shint_en)
    );

    assign io_rdata = (io_rd && hit_dat && open) ? rd_val : 8'hFF;
    assign cfg_mode = open;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk
    import sio_cfg_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          strap_alt,
    input logic [AW-1:0] io_addr,
    input logic          io_wr,
    input logic          io_rd,
    input logic [DW-1:0] io_wdata,
    input logic [DW-1:0] io_rdata,
    input logic          cfg_mode,
    input logic [BW-1:0] ser0_base,
    input logic [BW-1:0] ser1_base,
    input logic          ser0_en,
    input logic          ser1_en,
    input logic          par_en,
    input logic          shint_en,
    input logic [3:0]    ser0_irq,
    input logic [3:0]    ser1_irq,
    input logic [BW-1:0] par_base,
    input logic [1:0]    par_mode
);
    logic [AW-1:0] ip;
    assign ip = strap_alt ? 16'h0370 : 16'h03F0;

    a_r2_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && io_wr && io_addr == ip && io_wdata == 8'h55) |=> cfg_mode);

    a_r3_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && io_wr && io_addr == ip && io_wdata == 8'hAA) |=> !cfg_mode);

    a_r4_locked_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && io_rd) |-> io_rdata == 8'hFF);

    a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (ser0_base[2:0] == 3'b000) && (ser1_base[2:0] == 3'b000));

    a_r13_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> $stable({cfg_mode, ser0_base, ser1_base, par_base, ser0_irq,
                            ser1_irq, par_mode, ser0_en, ser1_en, par_en, shint_en}));

    a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mode && io_wr && io_wdata != 8'h55) |=> !cfg_mode);
endmodule

bind sio_cfg_port sio_cfg_port_chk u_chk (.*);

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_alt = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cfg_mode;
    logic [9:0]  ser0_base, ser1_base, par_base;
    logic [3:0]  ser0_irq, ser1_irq;
    logic [1:0]  par_mode;
    logic        ser0_en, ser1_en, par_en, shint_en;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] rd_got;

    always #2.5 clk = ~clk;

    sio_cfg_port u0 (.*);

    // kinds: 0 index write, 1 data write, 2 data read (expects e)
    typedef struct packed { logic [1:0] k; logic [7:0] d; logic [7:0] e; logic [3:0] rq; } vec_t;
    localparam int NV = 26;
    localparam vec_t VT [NV] = '{
        '{2'd0, 8'h0D, 8'h00, 4'd4},   // R4 index write while locked
        '{2'd2, 8'h00, 8'hFF, 4'd4},   // R4 locked read
        '{2'd1, 8'h80, 8'h00, 4'd4},   // R4 locked write ignored
        '{2'd0, 8'h55, 8'h00, 4'd2},   // R2 unlock
        '{2'd2, 8'h00, 8'h00, 4'd4},   // R4 valid still 0 after locked write
        '{2'd0, 8'h0D, 8'h00, 4'd5},
        '{2'd2, 8'h00, 8'h04, 4'd5},   // R5 device ID
        '{2'd1, 8'h77, 8'h00, 4'd5},
        '{2'd2, 8'h00, 8'h04, 4'd5},   // R5 write ignored
        '{2'd0, 8'h24, 8'h00, 4'd6},
        '{2'd1, 8'hFF, 8'h00, 4'd6},
        '{2'd2, 8'h00, 8'hFE, 4'd6},   // R6 bit0 forced low
        '{2'd0, 8'h25, 8'h00, 4'd6},
        '{2'd1, 8'hBE, 8'h00, 4'd6},
        '{2'd2, 8'h00, 8'hBE, 4'd6},
        '{2'd0, 8'h28, 8'h00, 4'd8},
        '{2'd1, 8'h21, 8'h00, 4'd8},
        '{2'd2, 8'h00, 8'h21, 4'd8},   // R8
        '{2'd0, 8'h40, 8'h00, 4'd11},
        '{2'd1, 8'h5A, 8'h00, 4'd11},
        '{2'd2, 8'h00, 8'h00, 4'd11},  // R11
        '{2'd0, 8'h00, 8'h00, 4'd9},
        '{2'd1, 8'h80, 8'h00, 4'd9},
        '{2'd2, 8'h00, 8'h80, 4'd9},   // R9
        '{2'd0, 8'hAA, 8'h00, 4'd3},   // R3 lock
        '{2'd2, 8'h00, 8'hFF, 4'd3}
    };

    task automatic check(input string rq, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", rq, got, exp);
        end
    endtask

    task automatic io(input int kind, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d;
        io_wr = (kind != 2); io_rd = (kind == 2);
        #1 rd_got = io_rdata;
        @(posedge clk);
        #0.5 io_wr = 1'b0; io_rd = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 cfg_mode", cfg_mode, 0);
        check("R12 outputs", {ser0_base, ser1_base, par_base, ser0_en, par_en, shint_en}, 0);

        for (int i = 0; i < NV; i++) begin
            io(VT[i].k, (VT[i].k == 0) ? 16'h03F0 : 16'h03F1, VT[i].d);
            if (VT[i].k == 2) check($sformatf("R%0d vec%0d", VT[i].rq, i), rd_got, VT[i].e);
        end
        @(negedge clk);
        check("R6 ser0_base", ser0_base, 10'h3F8);
        check("R6 ser1_base", ser1_base, 10'h2F8);
        check("R8 irqs", {ser0_irq, ser1_irq}, 8'h21);
        check("R9 enables", {ser0_en, ser1_en, par_en}, 3'b110);
        check("R3 cfg_mode", cfg_mode, 0);

        // R1: other strap location; old ports ignored
        strap_alt = 1'b1;
        io(0, 16'h03F0, 8'h55);
        @(negedge clk);
        check("R1 old port ignored", cfg_mode, 0);
        io(0, 16'h0370, 8'h55);
        @(negedge clk);
        check("R1 alt unlock", cfg_mode, 1);
        io(2, 16'h0371, 8'h00);
        check("R3 index cleared", rd_got, 8'h80);
        io(2, 16'h0372, 8'h00);
        check("R1 other address read", rd_got, 8'hFF);
        // R7
        io(0, 16'h0370, 8'h04); io(1, 16'h0371, 8'h03);
        io(0, 16'h0370, 8'h23); io(1, 16'h0371, 8'hDE);
        @(negedge clk);
        check("R7 par_mode", par_mode, 2'd3);
        check("R7 par_base", par_base, 10'h378);
        check("R9 par_en", par_en, 1);
        // R10
        io(0, 16'h0370, 8'h03); io(1, 16'h0371, 8'h80);
        @(negedge clk);
        check("R10 one bit only", shint_en, 0);
        io(1, 16'h0371, 8'h84);
        @(negedge clk);
        check("R10 both bits", shint_en, 1);
        // R9 clear valid
        io(0, 16'h0370, 8'h00); io(1, 16'h0371, 8'h00);
        @(negedge clk);
        check("R9 valid clear", {ser0_en, ser1_en, par_en, shint_en}, 4'b0000);
        // R12 reset
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 after reset", {cfg_mode, par_base, ser0_base, par_mode}, 0);
        io(0, 16'h0370, 8'h55); io(0, 16'h0370, 8'h0D); io(2, 16'h0371, 8'h00);
        check("R5 ID kept over reset", rd_got, 8'h04);
        io(0, 16'h0370, 8'h24); io(2, 16'h0371, 8'h00);
        check("R12 reg cleared", rd_got, 8'h00);
        io(0, 16'h0370, 8'hAA);
        @(negedge clk);
        check("R13 final lock", cfg_mode, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule